// File: doc/BRIEF.md
# Packed-Lane Divisor Normalizer

This block prepares divisor operands for a radix-2 SRT division datapath that works on packed integers. A 64-bit word is split into one 64-bit lane, two 32-bit lanes, four 16-bit lanes or eight 8-bit lanes, as chosen by a 3-bit size code. Each lane is first widened by one guard bit above its most significant bit. It is then shifted left as far as it can go without overflowing. The block reports the normalized value, the shift amount and a divide-by-zero flag for each lane.

The output word keeps ten bits for each 8-bit base chunk. These two spare bits per chunk give the redundant partial-remainder datapath downstream the headroom it needs. All inputs are sampled together when `in_valid` is high, and the results are registered. They appear on the outputs one clock later, and `out_valid` marks that cycle.

Top module: `simd_div_norm`

## Requirements
- R1: When `in_valid` is high at a rising clock edge, the results for that word drive the outputs after that edge, and `out_valid` is high for exactly that cycle. When `in_valid` is low, the result outputs keep their previous values and `out_valid` is low.
- R2: The lane width is picked by the highest set bit of `size_code`: bit 2 gives 64, bit 1 gives 32, bit 0 gives 16, and no set bit gives 8. Lane k of width W takes `in_word[W*k+W-1 : W*k]`.
- R3: Unsigned mode (`signed_mode`=0): the guard bit is 0 and the shift equals the number of leading zeros of the W-bit lane value. In the (W+1)-bit result, bit W is 0 and bit W-1 is 1.
- R4: Signed mode: the guard bit is a copy of the lane's sign bit. The shift equals the number of leading lane bits equal to the sign bit, so bits W and W-1 of the (W+1)-bit result differ.
- R5: A lane of c chunks owns `norm_word[10*c*k+10*c-1 : 10*c*k]`. Its low W+1 bits hold the shifted guard-plus-value word, with zeros shifted in at the bottom. The bits above copy bit W. Nothing moves across a lane boundary.
- R6: A lane whose value is zero sets its divide-by-zero flag, and its normalized field and shift count are zero.
- R7: Shift counts are 7-bit fields at `shift_cnt[7*j+6 : 7*j]` for base chunk j, and flags sit at `dz_flag[j]`. A lane writes only the field and the flag of its lowest chunk. All other fields and flags are zero.
- R8: After reset, `out_valid`, `norm_word`, `shift_cnt` and `dz_flag` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample the operand inputs this cycle |
| in_word | input | 64 | Packed divisor lanes |
| size_code | input | 3 | Lane width select, highest set bit wins |
| signed_mode | input | 1 | 1 = lanes are two's complement |
| out_valid | output | 1 | Results on the outputs are new this cycle |
| norm_word | output | 80 | Normalized lanes, 10 bits per base chunk |
| shift_cnt | output | 56 | Per-chunk 7-bit shift count fields |
| dz_flag | output | 8 | Per-chunk divide-by-zero flags |

## Verification
Single-bit lanes (values 1 and the top bit alone) separate the largest shift from no shift at all. Mixed-sign words in signed mode tell a correct copy of the sign into the guard bit from a plain zero guard. Small values such as 1, and the all-ones pattern, push the signed shift to its limit. Words whose set bits sit just above and just below a lane edge, applied at every lane size and with redundant size codes, show whether a shift leaks between lanes and whether the size priority is decoded correctly. Words with some zero lanes check that the zero forcing is confined to the lane it belongs to.

// File: rtl/simd_norm_pkg.sv
package simd_norm_pkg;

    localparam int CHUNK_BITS  = 8;
    localparam int CHUNK_COUNT = 8;
    localparam int CHUNK_EXT   = 10;
    localparam int COUNT_BITS  = 7;
    localparam int GROUPINGS   = 4;

    typedef enum logic [1:0] {
        LANE8  = 2'd0,
        LANE16 = 2'd1,
        LANE32 = 2'd2,
        LANE64 = 2'd3
    } lane_mode_e;

    typedef struct packed {
        logic [CHUNK_COUNT*CHUNK_EXT-1:0]  norm;
        logic [CHUNK_COUNT*COUNT_BITS-1:0] cnt;
        logic [CHUNK_COUNT-1:0]            dz;
    } norm_result_t;

    function automatic lane_mode_e decode_size(input logic [2:0] sz);
        if (sz[2])
            return LANE64;
        else if (sz[1])
            return LANE32;
        else if (sz[0])
            return LANE16;
        return LANE8;
    endfunction

endpackage

// File: rtl/norm_lane.sv
module norm_lane #(
    parameter int W       = 8,
    parameter int FIELD_W = 10,
    parameter int CNT_W   = 7
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [W-1:0]       val,
    input  logic               signed_mode,
    output logic [FIELD_W-1:0] field,
    output logic [CNT_W-1:0]   cnt,
    output logic               dz
);
    localparam int EW  = W + 1;
    localparam int PAD = FIELD_W - EW;

    logic          ref_bit;
    logic          stop;
    logic [CNT_W-1:0] run;
    logic [EW-1:0] ext;
    logic [EW-1:0] shifted;

    // Count leading bits equal to the reference bit (0 unsigned, sign signed)
    always_comb begin
        ref_bit = signed_mode & val[W-1];
        run     = '0;
        stop    = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            if (!stop) begin
                if (val[i] == ref_bit)
                    run = run + CNT_W'(1);
                else
                    stop = 1'b1;
            end
        end
    end

    assign dz  = (val == '0);
    assign ext = {ref_bit, val};

    always_comb begin
        if (dz) begin
            shifted = '0;
            cnt     = '0;
        end else begin
            shifted = ext << run;
            cnt     = run;
        end
    end

    assign field = {{PAD{shifted[W]}}, shifted};

    AST_UNS_NORM_RANGE: assert property (@(posedge clk) disable iff (rst)
        (!signed_mode && !dz) |-> (field[W] == 1'b0 && field[W-1] == 1'b1)); // R3

    AST_SGN_TOP_DIFFER: assert property (@(posedge clk) disable iff (rst)
        (signed_mode && !dz) |-> (field[W] != field[W-1])); // R4

    AST_SHIFT_BOUND: assert property (@(posedge clk) disable iff (rst)
        (int'(cnt) <= W)); // R3

    AST_ZERO_CLEARS: assert property (@(posedge clk) disable iff (rst)
        dz |-> (field == '0 && cnt == '0)); // R6

endmodule

// File: rtl/norm_width_bank.sv
module norm_width_bank #(
    parameter int G        = 0,
    parameter int CHUNK_W  = 8,
    parameter int NCHUNK   = 8,
    parameter int EXT_W    = 10,
    parameter int CNT_W    = 7
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NCHUNK*CHUNK_W-1:0]  word,
    input  logic                       signed_mode,
    output logic [NCHUNK*EXT_W-1:0]    norm,
    output logic [NCHUNK*CNT_W-1:0]    cnt,
    output logic [NCHUNK-1:0]          dz
);
    localparam int SPAN    = 1 << G;
    localparam int LANE_W  = CHUNK_W << G;
    localparam int FIELD_W = EXT_W << G;
    localparam int NLANE   = NCHUNK >> G;

    for (genvar k = 0; k < NLANE; k++) begin : g_lane
        logic [CNT_W-1:0] lane_cnt;
        logic             lane_dz;

        norm_lane #(
            .W       (LANE_W),
            .FIELD_W (FIELD_W),
            .CNT_W   (CNT_W)
        ) lane_i (
            .clk         (clk),
            .rst         (rst),
            .val         (word[k*LANE_W +: LANE_W]),
            .signed_mode (signed_mode),
            .field       (norm[k*FIELD_W +: FIELD_W]),
            .cnt         (lane_cnt),
            .dz          (lane_dz)
        );

        assign cnt[(k*SPAN)*CNT_W +: CNT_W] = lane_cnt;
        assign dz[k*SPAN]                   = lane_dz;
    end

    // Chunks that are not the lowest of their lane carry no count or flag
    for (genvar j = 0; j < NCHUNK; j++) begin : g_fill
        if ((j % SPAN) != 0) begin : g_zero
            assign cnt[j*CNT_W +: CNT_W] = '0;
            assign dz[j]                 = 1'b0;
        end
    end

endmodule

// File: rtl/simd_div_norm.sv
module simd_div_norm
    import simd_norm_pkg::*;
#(
    parameter int CHUNK_W = CHUNK_BITS,
    parameter int NCHUNK  = CHUNK_COUNT,
    parameter int EXT_W   = CHUNK_EXT,
    parameter int CNT_W   = COUNT_BITS
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      in_valid,
    input  logic [NCHUNK*CHUNK_W-1:0] in_word,
    input  logic [2:0]                size_code,
    input  logic                      signed_mode,
    output logic                      out_valid,
    output logic [NCHUNK*EXT_W-1:0]   norm_word,
    output logic [NCHUNK*CNT_W-1:0]   shift_cnt,
    output logic [NCHUNK-1:0]         dz_flag
);
    localparam int NORM_W = NCHUNK * EXT_W;
    localparam int CNTV_W = NCHUNK * CNT_W;

    logic [NORM_W-1:0] bank_norm [GROUPINGS];
    logic [CNTV_W-1:0] bank_cnt  [GROUPINGS];
    logic [NCHUNK-1:0] bank_dz   [GROUPINGS];

    for (genvar g = 0; g < GROUPINGS; g++) begin : g_bank
        norm_width_bank #(
            .G       (g),
            .CHUNK_W (CHUNK_W),
            .NCHUNK  (NCHUNK),
            .EXT_W   (EXT_W),
            .CNT_W   (CNT_W)
        ) bank_i (
            .clk         (clk),
            .rst         (rst),
            .word        (in_word),
            .signed_mode (signed_mode),
            .norm        (bank_norm[g]),
            .cnt         (bank_cnt[g]),
            .dz          (bank_dz[g])
        );
    end

    lane_mode_e mode;
    logic [NORM_W-1:0] sel_norm;
    logic [CNTV_W-1:0] sel_cnt;
    logic [NCHUNK-1:0] sel_dz;

    assign mode     = decode_size(size_code);
    assign sel_norm = bank_norm[mode];
    assign sel_cnt  = bank_cnt[mode];
    assign sel_dz   = bank_dz[mode];

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            norm_word <= '0;
            shift_cnt <= '0;
            dz_flag   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                norm_word <= sel_norm;
                shift_cnt <= sel_cnt;
                dz_flag   <= sel_dz;
            end
        end
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R1

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(norm_word) && $stable(shift_cnt))); // R1

    for (genvar j = 0; j < NCHUNK; j++) begin : g_chk
        AST_DZ_NO_SHIFT: assert property (@(posedge clk) disable iff (rst)
            dz_flag[j] |-> (shift_cnt[j*CNT_W +: CNT_W] == '0)); // R6
    end

endmodule

// File: tb/simd_div_norm_tb_top.sv
module simd_div_norm_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [63:0] in_word;
    logic [2:0]  size_code;
    logic        signed_mode;
    logic        out_valid;
    logic [79:0] norm_word;
    logic [55:0] shift_cnt;
    logic [7:0]  dz_flag;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    simd_div_norm dut_i (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .in_word     (in_word),
        .size_code   (size_code),
        .signed_mode (signed_mode),
        .out_valid   (out_valid),
        .norm_word   (norm_word),
        .shift_cnt   (shift_cnt),
        .dz_flag     (dz_flag)
    );

    // Independent model: shift one position at a time until normalized
    function automatic void model(input logic [63:0] w, input logic [2:0] sz, input bit sgn,
                                  output logic [79:0] en, output logic [55:0] ec,
                                  output logic [7:0] ed);
        int g, lw, nl, fw, s;
        logic [65:0] e;
        bit zero;
        g  = sz[2] ? 3 : (sz[1] ? 2 : (sz[0] ? 1 : 0));
        lw = 8 << g;
        nl = 8 >> g;
        fw = 10 << g;
        en = '0; ec = '0; ed = '0;
        for (int l = 0; l < nl; l++) begin
            e = '0;
            zero = 1'b1;
            for (int b = 0; b < lw; b++) begin
                e[b] = w[l*lw + b];
                if (e[b]) zero = 1'b0;
            end
            e[lw] = sgn ? e[lw-1] : 1'b0;
            s = 0;
            if (zero) begin
                e = '0;
            end else begin
                while (sgn ? (e[lw] == e[lw-1]) : (e[lw-1] == 1'b0)) begin
                    e = e << 1;
                    for (int b = lw + 1; b < 66; b++) e[b] = 1'b0;
                    s++;
                end
            end
            for (int b = 0; b < fw; b++)
                en[l*fw + b] = (b <= lw) ? e[b] : e[lw];
            ec[(l << g)*7 +: 7] = 7'(s);
            ed[l << g] = zero;
        end
    endfunction

    task automatic check(input string req, input string what, input logic [79:0] act,
                         input logic [79:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Apply one word and compare every output one cycle later
    task automatic apply(input logic [63:0] w, input logic [2:0] sz, input bit sgn,
                         input string req);
        logic [79:0] en;
        logic [55:0] ec;
        logic [7:0]  ed;
        model(w, sz, sgn, en, ec, ed);
        @(negedge clk);
        in_valid = 1'b1; in_word = w; size_code = sz; signed_mode = sgn;
        @(negedge clk);
        in_valid = 1'b0;
        check("R1", "out_valid", 80'(out_valid), 80'(1));
        check(req, "norm_word", norm_word, en);
        check({req, "/R7"}, "shift_cnt", 80'(shift_cnt), 80'(ec));
        check({req, "/R7"}, "dz_flag", 80'(dz_flag), 80'(ed));
    endtask

    task automatic t_reset;
        check("R8", "out_valid", 80'(out_valid), 80'(0));
        check("R8", "norm_word", norm_word, 80'(0));
        check("R8", "shift_cnt", 80'(shift_cnt), 80'(0));
        check("R8", "dz_flag", 80'(dz_flag), 80'(0));
    endtask

    task automatic t_unsigned_bytes;
        apply(64'h80_40_20_10_08_04_02_01, 3'b000, 1'b0, "R3");
        // Value 1 in an 8-bit lane: shift 7, field 10'h080
        check("R3", "byte0 field", 80'(norm_word[9:0]), 80'(10'h080));
        check("R3", "byte0 shift", 80'(shift_cnt[6:0]), 80'(7));
        apply(64'hFF_7F_3C_C3_01_FE_55_AA, 3'b000, 1'b0, "R3");
    endtask

    task automatic t_signed_lanes;
        apply(64'h80_40_FF_C0_01_7F_E0_10, 3'b000, 1'b1, "R4");
        apply(64'hFFFF_8000_0001_7FFF, 3'b001, 1'b1, "R4");
        apply(64'hFFFF_FFFF_0000_0003, 3'b010, 1'b1, "R4");
        apply(64'hFFFF_FFFF_FFFF_FFFF, 3'b100, 1'b1, "R4");
    endtask

    task automatic t_wide_lanes;
        apply(64'h0000_0001_8000_0000, 3'b010, 1'b0, "R5");
        apply(64'h0000_0000_0000_0001, 3'b100, 1'b0, "R5");
        apply(64'h0001_8000_0100_0080, 3'b001, 1'b0, "R5");
        apply(64'h0000_8000_0001_0000, 3'b001, 1'b1, "R5");
    endtask

    task automatic t_size_priority;
        apply(64'h0000_0001_0000_0001, 3'b111, 1'b0, "R2");
        apply(64'h0000_0001_0000_0001, 3'b011, 1'b0, "R2");
        apply(64'h0000_0001_0000_0001, 3'b101, 1'b1, "R2");
    endtask

    task automatic t_zero_lanes;
        apply(64'h00_12_00_00_80_00_01_00, 3'b000, 1'b0, "R6");
        apply(64'h0000_0000_0000_0000, 3'b100, 1'b1, "R6");
        apply(64'h0000_0000_FFFF_FFFF, 3'b010, 1'b1, "R6");
    endtask

    task automatic t_idle_hold;
        logic [79:0] n0;
        logic [55:0] c0;
        apply(64'h0102_0304_0506_0708, 3'b001, 1'b0, "R1");
        n0 = norm_word; c0 = shift_cnt;
        @(negedge clk);
        in_word = 64'hDEAD_BEEF_0000_0001; size_code = 3'b100; signed_mode = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R1", "idle out_valid", 80'(out_valid), 80'(0));
        check("R1", "idle norm hold", norm_word, n0);
        check("R1", "idle cnt hold", 80'(shift_cnt), 80'(c0));
    endtask

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_word = '0; size_code = '0; signed_mode = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_unsigned_bytes();
        t_signed_lanes();
        t_wide_lanes();
        t_size_priority();
        t_zero_lanes();
        t_idle_hold();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule